// File: doc/BRIEF.md
# Auto-Commit IN Packet Buffer

This block is the device-side front end of an IN endpoint. A producer on the interface clock pushes one element per write strobe, and the block groups the accepted elements into packets. In auto mode a packet is closed as soon as its element count equals a programmable length. A packet-end strobe closes the packet at any time, so the buffered elements leave as a short packet. That packet can be empty, or hold a single element that follows a full auto packet back to back. Packets are tracked only as length records. Each commit gives a one-cycle pulse with the packet length, and the most recently accepted element is shown beside it.

A counter of committed packets that wait to be drained drives the full and empty flags. A drain strobe retires one waiting packet. A packet-end that arrives on the same edge as the write that completes an auto packet is lost. The block latches this in a sticky error flag.

Top module: `inpkt_autocommit`

## Requirements
- R1: With `auto_en` high, the accepted write that brings the element count of the open packet equal to the active length commits that packet. On the following cycle `commit_vld` is 1 for exactly one cycle and `commit_len` holds that length.
- R2: A `pkt_end` that does not coincide with an auto-completing write commits the open packet with its current count. An element accepted on the same edge is included, and a count of zero gives a zero-length commit.
- R3: A single-element short packet, committed by `pkt_end` with a write on the edge right after an auto commit, is delivered as a separate commit of length 1.
- R4: A `pkt_end` on the same edge as an auto-completing write produces no extra commit and sets `pe_lost`. `pe_lost` stays 1 until reset.
- R5: `auto_len` (legal values 1 to 1024) is sampled only while the open packet holds no elements. A change made while a packet is partly filled takes effect for the next packet.
- R6: With `auto_en` low, no packet is committed by count, and only `pkt_end` commits.
- R7: `full` is 1 while the number of waiting committed packets equals `NBUF`. Writes and `pkt_end` made while `full` is 1 are ignored and leave the open packet unchanged.
- R8: `drain` retires one waiting packet per cycle. It has no effect when none wait. `empty` is 1 exactly when no committed packet waits.
- R9: `commit_tail` shows the element of the most recent accepted write, one cycle after that write.
- R10: After reset `commit_vld`, `full` and `pe_lost` are 0, `empty` is 1, `commit_tail` is 0 and the open packet is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one element per cycle |
| wr_data | input | DATA_W | Element being written |
| pkt_end | input | 1 | Commit the open packet as a short packet |
| auto_en | input | 1 | Enable commit by count |
| auto_len | input | LEN_W | Auto packet length, 1 to 1024 |
| drain | input | 1 | Retire one waiting committed packet |
| commit_vld | output | 1 | One-cycle pulse per committed packet |
| commit_len | output | LEN_W | Length of the packet just committed |
| commit_tail | output | DATA_W | Most recently accepted element |
| full | output | 1 | Waiting packet count equals NBUF |
| empty | output | 1 | No committed packet waiting |
| pe_lost | output | 1 | Sticky: a packet-end was dropped |

## Verification
Auto commits are tried with a plain run of writes and with a write that is joined by a packet-end. The first shows the length is reached by count alone. The second shows that a coincident packet-end is dropped and flagged, not turned into a second commit. A packet-end with a write on the edge after an auto commit, and a packet-end with no write, separate the one-element and zero-length short packets from the full ones. A length change made mid-packet shows that only the idle sample counts. A run with auto mode off shows that count alone never commits. A full condition followed by a zero-length commit shows that the blocked write never reached the counter. The limits of 1 and 1024 cover the smallest and largest packets.

// File: rtl/inpkt_autocommit.sv
module inpkt_autocommit #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 11,
  parameter int NBUF   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pkt_end,
  input  logic              auto_en,
  input  logic [LEN_W-1:0]  auto_len,
  input  logic              drain,
  output logic              commit_vld,
  output logic [LEN_W-1:0]  commit_len,
  output logic [DATA_W-1:0] commit_tail,
  output logic              full,
  output logic              empty,
  output logic              pe_lost
);

  localparam int PW = $clog2(NBUF + 1);

  logic [LEN_W-1:0] cnt, len_q, eff_len, cnt_inc;
  logic [PW-1:0]    pend;
  logic             accept, auto_hit, man_hit, commit, pop;

  assign full     = (pend == PW'(NBUF));
  assign empty    = (pend == '0);
  assign accept   = wr_en & ~full;
  assign eff_len  = (cnt == '0) ? auto_len : len_q;
  assign cnt_inc  = cnt + LEN_W'(accept);
  assign auto_hit = accept & auto_en & (cnt_inc == eff_len);
  assign man_hit  = pkt_end & ~full & ~auto_hit;
  assign commit   = auto_hit | man_hit;
  assign pop      = drain & ~empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      len_q       <= '0;
      pend        <= '0;
      commit_vld  <= 1'b0;
      commit_len  <= '0;
      commit_tail <= '0;
      pe_lost     <= 1'b0;
    end else begin
      len_q      <= eff_len;
      commit_vld <= commit;
      if (commit) begin
        cnt        <= '0;
        commit_len <= cnt_inc;
      end else if (accept) begin
        cnt <= cnt_inc;
      end
      if (accept)
        commit_tail <= wr_data;
      if (auto_hit && pkt_end)
        pe_lost <= 1'b1;
      pend <= pend + PW'(commit) - PW'(pop);
    end
  end

  assert_auto_commit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && auto_en && cnt_inc == eff_len) |=> (commit_vld && commit_len == $past(eff_len)));

  assert_manual_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && !full && !auto_hit) |=> (commit_vld && commit_len == $past(cnt_inc)));

  assert_lost_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pe_lost |=> pe_lost);

  assert_lost_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pe_lost) |-> $past(pkt_end && wr_en));

  assert_len_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !commit) |=> $stable(len_q));

  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(NBUF));

  assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !drain) |=> full);

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !commit) |=> empty);

endmodule

// File: tb/inpkt_autocommit_test.sv
module inpkt_autocommit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, pkt_end = 1'b0, auto_en = 1'b0, drain = 1'b0;
  logic [15:0] wr_data = '0;
  logic [10:0] auto_len = 11'd3;
  logic        commit_vld, full, empty, pe_lost;
  logic [10:0] commit_len;
  logic [15:0] commit_tail;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  inpkt_autocommit #(.DATA_W(16), .LEN_W(11), .NBUF(4)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pkt_end(pkt_end), .auto_en(auto_en), .auto_len(auto_len), .drain(drain),
    .commit_vld(commit_vld), .commit_len(commit_len), .commit_tail(commit_tail),
    .full(full), .empty(empty), .pe_lost(pe_lost));

  typedef struct packed {
    logic wr, pe, ae; logic [10:0] len; logic dr;
    logic ec; logic [10:0] el; logic ef, em, ee;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{1,0,1,3,0, 0,0,0,1,0},  // 0
    '{1,0,1,3,0, 0,0,0,1,0},  // 1
    '{1,0,1,3,0, 1,3,0,0,0},  // 2  R1 auto commit
    '{1,1,1,3,0, 1,1,0,0,0},  // 3  R3 one-element short packet
    '{0,1,1,3,0, 1,0,0,0,0},  // 4  R2 zero-length
    '{1,0,1,3,0, 0,0,0,0,0},  // 5
    '{1,0,1,3,0, 0,0,0,0,0},  // 6
    '{1,1,1,3,0, 1,3,1,0,1},  // 7  R4 coincident packet-end lost
    '{1,0,1,3,0, 0,0,1,0,1},  // 8  R7 write ignored
    '{1,1,1,3,0, 0,0,1,0,1},  // 9  R7 packet-end ignored
    '{0,0,1,3,1, 0,0,0,0,1},  // 10 R8 drain
    '{0,1,1,3,0, 1,0,1,0,1},  // 11 R7 zero length proves nothing buffered
    '{0,0,1,3,1, 0,0,0,0,1},  // 12
    '{0,0,1,3,1, 0,0,0,0,1},  // 13
    '{0,0,1,3,1, 0,0,0,0,1},  // 14
    '{0,0,1,3,1, 0,0,0,1,1},  // 15
    '{0,0,1,3,1, 0,0,0,1,1},  // 16 R8 drain at zero
    '{1,0,0,3,0, 0,0,0,1,1},  // 17 R6
    '{1,0,0,3,0, 0,0,0,1,1},  // 18
    '{1,0,0,3,0, 0,0,0,1,1},  // 19 R6 no commit at count 3
    '{0,1,0,3,0, 1,3,0,0,1},  // 20
    '{1,1,0,3,0, 1,1,0,0,1},  // 21
    '{1,0,1,2,0, 0,0,0,0,1},  // 22 R5 length 2 sampled idle
    '{1,0,1,5,0, 1,2,0,0,1},  // 23 R5 mid-packet change ignored
    '{1,0,1,5,0, 0,0,0,0,1},  // 24
    '{1,0,1,5,0, 0,0,0,0,1},  // 25
    '{1,0,1,5,0, 0,0,0,0,1},  // 26
    '{1,0,1,5,0, 0,0,0,0,1},  // 27
    '{1,0,1,5,0, 1,5,1,0,1}   // 28 R5 new length used
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic p, input logic d, input logic [15:0] dat);
    @(negedge clk);
    wr_en = w; pkt_end = p; drain = d; wr_data = dat;
    @(posedge clk);
    #5;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R10 reset commit_vld", commit_vld, 0);
    chk("R10 reset empty", empty, 1);
    chk("R10 reset full", full, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      auto_en = VEC[i].ae;
      auto_len = VEC[i].len;
      step(VEC[i].wr, VEC[i].pe, VEC[i].dr, 16'(i));
      chk($sformatf("R1/R2/R6 row %0d commit_vld", i), commit_vld, VEC[i].ec);
      if (VEC[i].ec)
        chk($sformatf("R1/R2/R3/R5 row %0d commit_len", i), commit_len, VEC[i].el);
      chk($sformatf("R7 row %0d full", i), full, VEC[i].ef);
      chk($sformatf("R8 row %0d empty", i), empty, VEC[i].em);
      chk($sformatf("R4 row %0d pe_lost", i), pe_lost, VEC[i].ee);
      if (VEC[i].wr && !(i == 8 || i == 9))
        chk($sformatf("R9 row %0d commit_tail", i), commit_tail, i);
    end

    // R10: reset from a full, errored state
    @(negedge clk);
    rst_n = 1'b0; wr_en = 0; pkt_end = 0; drain = 0;
    @(posedge clk); #5;
    chk("R10 reset pe_lost", pe_lost, 0);
    chk("R10 reset full after traffic", full, 0);
    chk("R10 reset empty after traffic", empty, 1);
    chk("R10 reset commit_tail", commit_tail, 0);
    @(negedge clk) rst_n = 1'b1;

    // R1 boundary: length 1, every write commits
    auto_en = 1'b1; auto_len = 11'd1;
    for (int k = 0; k < 3; k++) begin
      step(1, 0, 1, 16'h100 + 16'(k));
      chk("R1 len1 commit_vld", commit_vld, 1);
      chk("R1 len1 commit_len", commit_len, 1);
    end
    step(0, 0, 1, 16'h0);
    chk("R1 len1 idle no commit", commit_vld, 0);
    chk("R8 drained empty", empty, 1);

    // R1/R5 boundary: length 1024
    auto_len = 11'd1024;
    begin
      int early = 0;
      for (int k = 0; k < 1023; k++) begin
        step(1, 0, 0, 16'(k));
        if (commit_vld) early++;
      end
      chk("R1 len1024 no early commit", early, 0);
    end
    step(1, 0, 0, 16'hBEEF);
    chk("R1 len1024 commit_vld", commit_vld, 1);
    chk("R1 len1024 commit_len", commit_len, 1024);
    chk("R9 len1024 commit_tail", commit_tail, 16'hBEEF);
    chk("R4 no spurious pe_lost", pe_lost, 0);
    step(0, 0, 0, 16'h0);
    chk("R1 single pulse", commit_vld, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule